// File: doc/BRIEF.md
# Fractional High-Speed UART Baud Generator

This block generates the bit timing for a 16550-style serial port, including rates above one sixteenth of the core clock. A clock prescaler driven by the divisor latch makes a divided tick. A tick counter groups these ticks into bit periods and marks where each bit ends and where the receive line should be sampled. It also counts the bits of the current frame.

Two timing modes are available. Standard mode uses a fixed sixteen ticks per bit and samples on tick 7. High-speed mode uses a programmable number of ticks per bit and a programmable sample tick. In high-speed mode, a 10-bit stretch mask can add one tick to selected bits of the frame, which spreads the fractional part of the clock-to-baud ratio across the frame.

Software writes a shadow register set through a byte-wide write port. A frame-start pulse copies the shadow set into the working set and restarts all counters. The receiver raises that pulse on each start-bit edge, so every frame re-aligns to the line.

Top module: `uart_baud_frac_gen`

## Requirements
- R1: After reset, all three strobes are low and the bit index is 0. Reset values are: divisor 0, mode 0, tick count 0x00, sample tick 0xFF, stretch mask 0. A frame started with no writes therefore runs in standard mode with a tick on every clock.
- R2: Writes to address 0 (divisor bits 7:0) and address 1 (divisor bits 15:8) are ignored unless `div_access` is high. Writes to addresses 2 to 6 are always accepted.
- R3: When the mode field (address 2, bits 1:0) is not 3, each bit lasts 16 ticks. A tick occurs every divisor clocks. The sample strobe fires on tick 7 of each bit, counting from 0.
- R4: When the mode field is 3, each bit lasts (tick count + 1) ticks, with the tick count at address 3. The sample strobe fires on the tick whose index equals the sample tick at address 4.
- R5: In mode 3, if bit k of the stretch mask is set, bit k of the frame lasts one extra tick. Mask bits 7:0 come from address 5 and mask bits 9:8 from address 6, bits 1:0. Frame bits 10 and above are never stretched. The mask has no effect in standard mode.
- R6: A divisor of 0 gives the same timing as a divisor of 1.
- R7: Register writes do not change the timing of the frame in progress. They take effect at the next frame-start pulse. A write in the same cycle as the pulse waits for the pulse after that.
- R8: A frame-start pulse clears the prescaler, the tick counter and the bit index. No strobe is raised in the cycle of the pulse. The first tick comes divisor clocks after the pulse.
- R9: The bit index starts at 0 after a frame start. It increments on each bit-boundary strobe and wraps modulo 16.
- R10: In mode 3, a sample tick that is not below the bit length never produces a sample strobe. Bit-boundary strobes continue as normal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0..6) |
| wr_data | input | 8 | Register write data |
| div_access | input | 1 | Divisor latch access enable from line control |
| frame_start | input | 1 | Frame-start pulse: loads settings and restarts counters |
| tick | output | 1 | Divided-clock tick |
| bit_strobe | output | 1 | One-clock pulse on the last tick of a bit |
| sample_strobe | output | 1 | One-clock pulse on the receive sample tick |
| bit_idx | output | 4 | Index of the current bit within the frame |

## Verification
The hardest cases to reach are those where the shadow and working settings differ. This happens when a write lands in the middle of a frame, or when a frame-start pulse cuts a bit short. The bench covers both with directed frames. One frame writes new mode and count values partway through, and the next frame checks that they take effect only then. Another frame is restarted after a fixed number of clocks, part way through a bit. Stretch masks on bits 10 and above, and sample ticks beyond the bit length, are reached through long frames and random configurations.

// File: rtl/uart_bg_pkg.sv
`timescale 1ns/1ps
package uart_bg_pkg;
  typedef enum logic [2:0] {
    ADR_DIV_LO  = 3'd0,
    ADR_DIV_HI  = 3'd1,
    ADR_MODE    = 3'd2,
    ADR_SCNT    = 3'd3,
    ADR_SPT     = 3'd4,
    ADR_FRAC_LO = 3'd5,
    ADR_FRAC_HI = 3'd6
  } reg_addr_e;

  localparam logic [1:0] MODE_HS     = 2'd3;
  localparam int         STD_OVS     = 16;
  localparam int         STD_SAMPLE  = 7;
  localparam logic [7:0] SPT_RESET   = 8'hFF;
endpackage

// File: rtl/uart_bg_rst_sync.sv
`timescale 1ns/1ps
module uart_bg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/uart_bg_regs.sv
`timescale 1ns/1ps
module uart_bg_regs
  import uart_bg_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              div_access,
  input  logic              load,
  output logic [DIV_W-1:0]  act_div,
  output logic              act_hs,
  output logic [7:0]        act_scnt,
  output logic [7:0]        act_spt,
  output logic [FRAC_W-1:0] act_mask
);
  localparam int HI_W = DIV_W - 8;
  localparam int FH_W = FRAC_W - 8;

  logic [DIV_W-1:0]  sh_div_q,  sh_div_d;
  logic [1:0]        sh_mode_q, sh_mode_d;
  logic [7:0]        sh_scnt_q, sh_scnt_d;
  logic [7:0]        sh_spt_q,  sh_spt_d;
  logic [FRAC_W-1:0] sh_mask_q, sh_mask_d;

  logic [DIV_W-1:0]  ac_div_q;
  logic              ac_hs_q;
  logic [7:0]        ac_scnt_q, ac_spt_q;
  logic [FRAC_W-1:0] ac_mask_q;

  always_comb begin
    sh_div_d  = sh_div_q;
    sh_mode_d = sh_mode_q;
    sh_scnt_d = sh_scnt_q;
    sh_spt_d  = sh_spt_q;
    sh_mask_d = sh_mask_q;
    if (wr_en) begin
      unique case (reg_addr_e'(wr_addr))
        ADR_DIV_LO:  if (div_access) sh_div_d[7:0] = wr_data;
        ADR_DIV_HI:  if (div_access) sh_div_d[DIV_W-1:8] = wr_data[HI_W-1:0];
        ADR_MODE:    sh_mode_d = wr_data[1:0];
        ADR_SCNT:    sh_scnt_d = wr_data;
        ADR_SPT:     sh_spt_d  = wr_data;
        ADR_FRAC_LO: sh_mask_d[7:0] = wr_data;
        ADR_FRAC_HI: sh_mask_d[FRAC_W-1:8] = wr_data[FH_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_div_q  <= '0;
      sh_mode_q <= '0;
      sh_scnt_q <= '0;
      sh_spt_q  <= SPT_RESET;
      sh_mask_q <= '0;
    end else begin
      sh_div_q  <= sh_div_d;
      sh_mode_q <= sh_mode_d;
      sh_scnt_q <= sh_scnt_d;
      sh_spt_q  <= sh_spt_d;
      sh_mask_q <= sh_mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_div_q  <= '0;
      ac_hs_q   <= 1'b0;
      ac_scnt_q <= '0;
      ac_spt_q  <= SPT_RESET;
      ac_mask_q <= '0;
    end else if (load) begin
      ac_div_q  <= sh_div_q;
      ac_hs_q   <= (sh_mode_q == MODE_HS);
      ac_scnt_q <= sh_scnt_q;
      ac_spt_q  <= sh_spt_q;
      ac_mask_q <= sh_mask_q;
    end
  end

  assign act_div  = (ac_div_q == '0) ? DIV_W'(1) : ac_div_q;
  assign act_hs   = ac_hs_q;
  assign act_scnt = ac_scnt_q;
  assign act_spt  = ac_spt_q;
  assign act_mask = ac_mask_q;
endmodule

// File: rtl/uart_bg_timing.sv
`timescale 1ns/1ps
module uart_bg_timing
  import uart_bg_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 10,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIV_W-1:0]  act_div,
  input  logic              act_hs,
  input  logic [7:0]        act_scnt,
  input  logic [7:0]        act_spt,
  input  logic [FRAC_W-1:0] act_mask,
  output logic              tick,
  output logic              bit_stb,
  output logic              smp_stb,
  output logic [IDX_W-1:0]  bit_idx
);
  localparam int LEN_W = 9;

  logic [DIV_W-1:0] presc_q, presc_d;
  logic [LEN_W-1:0] tcnt_q,  tcnt_d;
  logic [IDX_W-1:0] idx_q,   idx_d;

  logic             stretch;
  logic [LEN_W-1:0] bit_len;
  logic [LEN_W-1:0] smp_at;
  logic             tick_int, wrap;

  always_comb begin
    stretch = 1'b0;
    for (int k = 0; k < FRAC_W; k++) begin
      if (int'(idx_q) == k) stretch = act_mask[k];
    end
    bit_len  = act_hs ? (LEN_W'(act_scnt) + LEN_W'(1) + LEN_W'(stretch))
                      : LEN_W'(STD_OVS);
    smp_at   = act_hs ? LEN_W'(act_spt) : LEN_W'(STD_SAMPLE);
    tick_int = rst_n && !start && (presc_q == act_div - DIV_W'(1));
    wrap     = tick_int && (tcnt_q == bit_len - LEN_W'(1));
  end

  always_comb begin
    presc_d = presc_q;
    tcnt_d  = tcnt_q;
    idx_d   = idx_q;
    if (start) begin
      presc_d = '0;
      tcnt_d  = '0;
      idx_d   = '0;
    end else if (tick_int) begin
      presc_d = '0;
      if (wrap) begin
        tcnt_d = '0;
        idx_d  = idx_q + IDX_W'(1);
      end else begin
        tcnt_d = tcnt_q + LEN_W'(1);
      end
    end else begin
      presc_d = presc_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      tcnt_q  <= '0;
      idx_q   <= '0;
    end else begin
      presc_q <= presc_d;
      tcnt_q  <= tcnt_d;
      idx_q   <= idx_d;
    end
  end

  assign tick    = tick_int;
  assign bit_stb = wrap;
  assign smp_stb = tick_int && (tcnt_q == smp_at);
  assign bit_idx = idx_q;
endmodule

// File: rtl/uart_baud_frac_gen.sv
`timescale 1ns/1ps
module uart_baud_frac_gen #(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 10,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             div_access,
  input  logic             frame_start,
  output logic             tick,
  output logic             bit_strobe,
  output logic             sample_strobe,
  output logic [IDX_W-1:0] bit_idx
);
  logic              rst_s_n;
  logic [DIV_W-1:0]  act_div;
  logic              act_hs;
  logic [7:0]        act_scnt, act_spt;
  logic [FRAC_W-1:0] act_mask;

  uart_bg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  uart_bg_regs #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .div_access(div_access), .load(frame_start),
    .act_div(act_div), .act_hs(act_hs), .act_scnt(act_scnt),
    .act_spt(act_spt), .act_mask(act_mask)
  );

  uart_bg_timing #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .IDX_W(IDX_W)) u_tim (
    .clk(clk), .rst_n(rst_s_n), .start(frame_start), .act_div(act_div),
    .act_hs(act_hs), .act_scnt(act_scnt), .act_spt(act_spt),
    .act_mask(act_mask), .tick(tick), .bit_stb(bit_strobe),
    .smp_stb(sample_strobe), .bit_idx(bit_idx)
  );
endmodule

// File: rtl/uart_baud_frac_gen_chk.sv
`timescale 1ns/1ps
module uart_baud_frac_gen_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             tick,
  input logic             bit_strobe,
  input logic             sample_strobe,
  input logic [IDX_W-1:0] bit_idx
);
  AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (!tick && !bit_strobe && !sample_strobe)); // R8

  AST_START_CLEARS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (bit_idx == '0)); // R9

  AST_BOUNDARY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> tick); // R3

  AST_SAMPLE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> tick); // R4

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |=> (bit_idx == $past(bit_idx) + IDX_W'(1))); // R9

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_strobe && !frame_start) |=> $stable(bit_idx)); // R9
endmodule

bind uart_baud_frac_gen uart_baud_frac_gen_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .tick(tick),
  .bit_strobe(bit_strobe), .sample_strobe(sample_strobe), .bit_idx(bit_idx)
);

// File: tb/uart_baud_frac_gen_test.sv
`timescale 1ns/1ps
module uart_baud_frac_gen_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, div_access, frame_start;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic       tick, bit_strobe, sample_strobe;
  logic [3:0] bit_idx;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // shadow and working configuration model
  int sh_div, sh_mode, sh_sc, sh_sp, sh_mask;
  int ac_div, ac_mode, ac_sc, ac_sp, ac_mask;

  always #10 clk = ~clk;

  uart_baud_frac_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .div_access(div_access), .frame_start(frame_start),
    .tick(tick), .bit_strobe(bit_strobe), .sample_strobe(sample_strobe),
    .bit_idx(bit_idx)
  );

  function automatic int blen(int k);
    if (ac_mode == 3)
      return ac_sc + 1 + (((k < 10) && ac_mask[k]) ? 1 : 0);
    return 16;
  endfunction

  function automatic int eff_div();
    return (ac_div == 0) ? 1 : ac_div;
  endfunction

  // expected {tick, bit_strobe, sample_strobe, idx[3:0]} in cycle n after start
  function automatic logic [6:0] expect_at(int n);
    int d = eff_div();
    int done_t = (n - 1) / d;
    int k = 0;
    int len = blen(0);
    int spos = (ac_mode == 3) ? ac_sp : 7;
    logic t, b, s;
    for (int g = 0; g < 100000; g++) begin
      len = blen(k);
      if (done_t < len) break;
      done_t -= len;
      k++;
    end
    t = ((n % d) == 0);
    b = t && (done_t == len - 1);
    s = t && (done_t == spos);
    return {t, b, s, 4'(k % 16)};
  endfunction

  function automatic int frame_cycles(int nbits);
    int sum = 0;
    for (int k = 0; k < nbits; k++) sum += blen(k);
    return sum * eff_div();
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_write(int a, int d, bit dla);
    case (a)
      0: if (dla) sh_div = (sh_div & 16'hFF00) | d;
      1: if (dla) sh_div = (sh_div & 16'h00FF) | (d << 8);
      2: sh_mode = d & 3;
      3: sh_sc = d;
      4: sh_sp = d;
      5: sh_mask = (sh_mask & 10'h300) | d;
      6: sh_mask = (sh_mask & 10'h0FF) | ((d & 3) << 8);
      default: ;
    endcase
  endtask

  task automatic wr(int a, int d, bit dla);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d); div_access = dla;
    @(negedge clk);
    wr_en = 1'b0; div_access = 1'b0;
    model_write(a, d, dla);
  endtask

  // run one frame; optional mid-frame write at cycle wr_at; ncyc>0 truncates
  task automatic frame(string req, int nbits, int ncyc, int wr_at,
                       int wa, int wd);
    int n_total;
    int bad_t = 0, bad_b = 0, bad_s = 0, bad_i = 0;
    int at_t = 0, at_b = 0, at_s = 0, at_i = 0;
    int ex_t = 0, ex_b = 0, ex_s = 0, ex_i = 0;
    logic [6:0] e;
    @(negedge clk);
    frame_start = 1'b1;
    #1;
    check(req, "strobes during frame start",
          int'({tick, bit_strobe, sample_strobe}), 0);
    ac_div = sh_div; ac_mode = sh_mode; ac_sc = sh_sc;
    ac_sp = sh_sp;   ac_mask = sh_mask;
    n_total = (ncyc > 0) ? ncyc : frame_cycles(nbits);
    @(negedge clk);
    frame_start = 1'b0;
    for (int n = 1; n <= n_total; n++) begin
      #1;
      e = expect_at(n);
      if (tick !== e[6] && bad_t == 0) begin bad_t = n; at_t = int'(tick); ex_t = int'(e[6]); end
      if (bit_strobe !== e[5] && bad_b == 0) begin bad_b = n; at_b = int'(bit_strobe); ex_b = int'(e[5]); end
      if (sample_strobe !== e[4] && bad_s == 0) begin bad_s = n; at_s = int'(sample_strobe); ex_s = int'(e[4]); end
      if (bit_idx !== e[3:0] && bad_i == 0) begin bad_i = n; at_i = int'(bit_idx); ex_i = int'(e[3:0]); end
      if (n == wr_at) begin
        wr_en = 1'b1; wr_addr = 3'(wa); wr_data = 8'(wd); div_access = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; div_access = 1'b0;
        model_write(wa, wd, 1'b1);
      end else begin
        @(negedge clk);
      end
    end
    if (bad_t != 0) $display("  first tick mismatch at cycle %0d", bad_t);
    check(req, "tick", at_t, ex_t);
    if (bad_b != 0) $display("  first bit strobe mismatch at cycle %0d", bad_b);
    check(req, "bit strobe", at_b, ex_b);
    if (bad_s != 0) $display("  first sample mismatch at cycle %0d", bad_s);
    check(req, "sample strobe", at_s, ex_s);
    if (bad_i != 0) $display("  first bit index mismatch at cycle %0d", bad_i);
    check(req, "bit index", at_i, ex_i);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    div_access = 1'b0; frame_start = 1'b0;
    sh_div = 0; sh_mode = 0; sh_sc = 0; sh_sp = 255; sh_mask = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "tick in reset", int'(tick), 0);
    check("R1", "bit strobe in reset", int'(bit_strobe), 0);
    check("R1", "sample in reset", int'(sample_strobe), 0);
    check("R1", "bit index in reset", int'(bit_idx), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    frame("R1", 12, 0, 0, 0, 0);                 // defaults: standard, div 1
    wr(0, 3, 1'b1); wr(1, 0, 1'b1);
    frame("R3", 11, 0, 0, 0, 0);                 // standard, divisor 3
    wr(0, 0, 1'b1);
    frame("R6", 11, 0, 0, 0, 0);                 // divisor 0 acts as 1
    wr(0, 5, 1'b0); wr(1, 2, 1'b0);
    frame("R2", 11, 0, 0, 0, 0);                 // divisor write ignored
    wr(0, 2, 1'b1); wr(2, 3, 1'b0); wr(3, 9, 1'b0); wr(4, 3, 1'b0);
    frame("R4", 11, 0, 0, 0, 0);                 // high speed
    wr(5, 8'h55, 1'b0); wr(6, 3, 1'b0);
    frame("R5", 13, 0, 0, 0, 0);                 // stretch mask incl. bits 10+
    wr(2, 0, 1'b0);
    frame("R5", 11, 0, 0, 0, 0);                 // mask ignored in standard
    wr(2, 3, 1'b0); wr(4, 8'hFF, 1'b0);
    frame("R10", 11, 0, 0, 0, 0);                // sample tick out of range
    wr(4, 4, 1'b0);
    frame("R7", 11, 0, 40, 3, 5);                // mid-frame write waits
    frame("R7", 11, 0, 0, 0, 0);                 // new tick count now applies
    frame("R8", 11, 37, 0, 0, 0);                // cut short mid-bit
    frame("R8", 11, 0, 0, 0, 0);                 // restart realigns
    wr(2, 0, 1'b0); wr(0, 1, 1'b1);
    frame("R9", 19, 0, 0, 0, 0);                 // index wraps past 15

    for (int i = 0; i < 30; i++) begin
      int sc = 3 + int'($urandom % 22);
      wr(0, int'($urandom % 5), 1'b1);
      wr(2, int'($urandom % 4), 1'b0);
      wr(3, sc, 1'b0);
      wr(4, int'($urandom % (sc + 3)), 1'b0);
      wr(5, int'($urandom % 256), 1'b0);
      wr(6, int'($urandom % 4), 1'b0);
      frame("R4", 12, 0, 0, 0, 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule